// File: doc/BRIEF.md
# Radix-1024 Carry-Save Iterative Multiplier

This block multiplies two integer operands over several clock cycles and produces ten product bits per cycle. Each step takes ten bits of the multiplier, least significant first, and forms ten shifted copies of the multiplicand. A carry-save compressor adds these copies to the resolved running sum from the previous step. The compressor output is kept as an unresolved sum/carry pair in registers. One shared full-width adder resolves that pair. The low ten bits of the adder result go into the low result register. The arithmetically shifted remainder feeds the next step of the compressor. No separate final adder sits at the end of the compressor.

The caller gives two 64-bit operands, a signedness flag and a width class. The width class says how many low operand bits are meaningful, and it sets how many steps the operation runs. Narrow operands therefore finish earlier. Unsigned operands are zero-extended by at least one bit, so the same signed partial-product logic serves both modes. The multiplier's sign weight is removed by subtracting the top partial product in the final step. The full 128-bit product appears on the HI and LO outputs when `done` pulses.

Top module: `csa_iter_mul`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `busy`, `done`, `hi` and `lo` are all zero.
- R2: `wclass` selects the operand width: 0 = 24 bits, 1 = 32 bits, 2 = 54 bits, 3 = 64 bits. The result {hi, lo} is the 128-bit two's-complement product of the two extended operands: `hi` holds bits 127:64 and `lo` holds bits 63:0.
- R3: With `is_signed` = 1, each operand's low width bits are taken as a two's-complement number. This includes the most negative value and all ones (minus one).
- R4: With `is_signed` = 0, each operand's low width bits are taken as an unsigned number, zero-extended.
- R5: `done` is high N clock edges after the edge that accepts a start, with N = 3, 4, 6 and 7 for width classes 0, 1, 2 and 3.
- R6: An accepted start raises `busy` on the next cycle. `busy` stays high until the edge that raises `done`. `done` is high for exactly one cycle. `busy` and `done` are never high together.
- R7: A `start` presented while `busy` is high is ignored. The running operation keeps its operands, mode, latency and result.
- R8: `hi` changes only on the edge that raises `done`. After completion, `hi` and `lo` keep the result until the next start is accepted.
- R9: A `start` presented in the cycle where `done` is high is accepted. The new operation has its own correct latency and result.
- R10: Operand bits at and above the selected width have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request, accepted when not busy |
| is_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| wclass | input | 2 | Operand width class (0:24, 1:32, 2:54, 3:64 bits) |
| opa | input | 64 | Multiplicand |
| opb | input | 64 | Multiplier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: hi/lo hold a new product |
| hi | output | 64 | Upper half of the product |
| lo | output | 64 | Lower half of the product |

## Verification
The product is due exactly 3, 4, 6 or 7 rising edges after the accepting edge, depending on the width class. The bench drives `start` at a falling edge. It then counts falling edges until `done` is seen, compares that count with the expected step count, and samples `hi`/`lo` in that same half cycle. A poke during `busy` is applied one cycle after acceptance, and the hold check samples three idle cycles after `done`. Back-to-back operations raise `start` in the same half cycle in which `done` was observed, so the next accept falls on the edge that ends the `done` pulse.

// File: rtl/cim_pkg.sv
package cim_pkg;
  localparam int OP_W   = 64;
  localparam int DIG    = 10;
  localparam int ACC_W  = OP_W + DIG + 2;
  localparam int PROD_W = 2 * OP_W;
  localparam int WIDE_W = PROD_W + DIG;
  localparam int CNT_W  = $clog2((OP_W + DIG) / DIG + 1);

  localparam logic [1:0] WC_24 = 2'd0;
  localparam logic [1:0] WC_32 = 2'd1;
  localparam logic [1:0] WC_54 = 2'd2;
  localparam logic [1:0] WC_64 = 2'd3;

  // operand width selected by a class code
  function automatic int class_bits(input logic [1:0] wc);
    case (wc)
      WC_24:   return 24;
      WC_32:   return 32;
      WC_54:   return 54;
      default: return OP_W;
    endcase
  endfunction

  // steps needed: ceil((width + 1) / DIG), the +1 leaves room for zero extension
  function automatic logic [CNT_W-1:0] class_steps(input logic [1:0] wc);
    return CNT_W'((class_bits(wc) + DIG) / DIG);
  endfunction

  // sign- or zero-extend the low class bits to the accumulator width
  function automatic logic [ACC_W-1:0] ext_operand(input logic [OP_W-1:0] v,
                                                   input logic [1:0] wc,
                                                   input logic sg);
    int w;
    logic fill;
    logic [ACC_W-1:0] r;
    w = class_bits(wc);
    case (wc)
      WC_24:   fill = v[23];
      WC_32:   fill = v[31];
      WC_54:   fill = v[53];
      default: fill = v[OP_W-1];
    endcase
    fill = fill & sg;
    for (int i = 0; i < ACC_W; i++) r[i] = fill;
    for (int i = 0; i < OP_W; i++) if (i < w) r[i] = v[i];
    return r;
  endfunction

  // one 3:2 carry-save stage, returns {sum, carry}
  function automatic logic [2*ACC_W-1:0] csa3(input logic [ACC_W-1:0] x,
                                              input logic [ACC_W-1:0] y,
                                              input logic [ACC_W-1:0] z);
    logic [ACC_W-1:0] s, m;
    s = x ^ y ^ z;
    m = (x & y) | (x & z) | (y & z);
    return {s, m << 1};
  endfunction

  // join the resolved top part with the bits already shifted into LO
  function automatic logic [PROD_W-1:0] assemble(input logic [ACC_W-1:0] y,
                                                 input logic [OP_W-1:0] low,
                                                 input logic [CNT_W-1:0] steps);
    int sh;
    logic [WIDE_W-1:0] wide, tail;
    sh   = DIG * (int'(steps) - 1);
    wide = {{(WIDE_W-ACC_W){y[ACC_W-1]}}, y};
    wide = wide << sh;
    tail = WIDE_W'(low) >> (OP_W - sh);
    return PROD_W'(wide | tail);
  endfunction
endpackage

// File: rtl/cim_ppgen.sv
module cim_ppgen
  import cim_pkg::*;
(
  input  logic [ACC_W-1:0]          mcand,
  input  logic [DIG-1:0]            digit,
  input  logic                      neg_top,
  output logic [DIG-1:0][ACC_W-1:0] pp,
  output logic                      inj
);
  genvar j;
  generate
    for (j = 0; j < DIG; j++) begin : g_pp
      if (j == DIG - 1) begin : g_top
        // last step: the multiplier sign bit carries negative weight
        assign pp[j] = (neg_top && digit[j]) ? ~(mcand << j)
                     : (digit[j] ? (mcand << j) : '0);
      end else begin : g_low
        assign pp[j] = digit[j] ? (mcand << j) : '0;
      end
    end
  endgenerate

  // +1 of the two's-complement negation, injected at the carry LSB
  assign inj = neg_top & digit[DIG-1];
endmodule

// File: rtl/cim_csa.sv
module cim_csa
  import cim_pkg::*;
(
  input  logic [DIG-1:0][ACC_W-1:0] pp,
  input  logic [ACC_W-1:0]          fb,
  input  logic                      inj,
  output logic [ACC_W-1:0]          sum,
  output logic [ACC_W-1:0]          carry
);
  logic [ACC_W-1:0] s_ch [DIG+1];
  logic [ACC_W-1:0] c_ch [DIG+1];

  assign s_ch[0] = fb;
  assign c_ch[0] = {{(ACC_W-1){1'b0}}, inj};

  genvar j;
  generate
    for (j = 0; j < DIG; j++) begin : g_stage
      assign {s_ch[j+1], c_ch[j+1]} = csa3(s_ch[j], c_ch[j], pp[j]);
    end
  endgenerate

  assign sum   = s_ch[DIG];
  assign carry = c_ch[DIG];
endmodule

// File: rtl/cim_ctrl.sv
module cim_ctrl
  import cim_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       wclass,
  output logic             busy,
  output logic             done,
  output logic             accept,
  output logic             step_en,
  output logic             finish,
  output logic             neg_top,
  output logic [CNT_W-1:0] steps
);
  logic [CNT_W-1:0] left_q;
  logic [CNT_W-1:0] req_steps;

  assign req_steps = class_steps(wclass);
  assign accept    = start & ~busy;
  assign step_en   = busy & (left_q != '0);
  assign finish    = busy & (left_q == '0);
  assign neg_top   = busy ? (left_q == CNT_W'(1)) : (req_steps == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      left_q <= '0;
      steps  <= '0;
    end else begin
      done <= finish;
      if (accept) begin
        busy   <= 1'b1;
        left_q <= req_steps - CNT_W'(1);
        steps  <= req_steps;
      end else if (finish) begin
        busy <= 1'b0;
      end else if (step_en) begin
        left_q <= left_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/csa_iter_mul.sv
module csa_iter_mul
  import cim_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            is_signed,
  input  logic [1:0]      wclass,
  input  logic [OP_W-1:0] opa,
  input  logic [OP_W-1:0] opb,
  output logic            busy,
  output logic            done,
  output logic [OP_W-1:0] hi,
  output logic [OP_W-1:0] lo
);
  // events shared between control and datapath
  logic             accept, step_en, finish, neg_top;
  logic [CNT_W-1:0] steps;

  logic [ACC_W-1:0] a_in, b_in;
  logic [ACC_W-1:0] areg, bsr, sreg, creg;
  logic [ACC_W-1:0] y, y_shr;
  logic [ACC_W-1:0] mcand, fb;
  logic [DIG-1:0]   digit;
  logic [DIG-1:0][ACC_W-1:0] pp;
  logic             inj;
  logic [ACC_W-1:0] csa_s, csa_c;
  logic [PROD_W-1:0] fin;

  cim_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .wclass  (wclass),
    .busy    (busy),
    .done    (done),
    .accept  (accept),
    .step_en (step_en),
    .finish  (finish),
    .neg_top (neg_top),
    .steps   (steps)
  );

  assign a_in  = ext_operand(opa, wclass, is_signed);
  assign b_in  = ext_operand(opb, wclass, is_signed);

  // the single carry-propagate adder, shared by feedback and final result
  assign y     = sreg + creg;
  assign y_shr = ACC_W'($signed(y) >>> DIG);

  // the first step runs in the accepting cycle straight from the inputs
  assign mcand = busy ? areg : a_in;
  assign digit = busy ? bsr[DIG-1:0] : b_in[DIG-1:0];
  assign fb    = busy ? y_shr : '0;

  cim_ppgen u_ppgen (
    .mcand   (mcand),
    .digit   (digit),
    .neg_top (neg_top),
    .pp      (pp),
    .inj     (inj)
  );

  cim_csa u_csa (
    .pp    (pp),
    .fb    (fb),
    .inj   (inj),
    .sum   (csa_s),
    .carry (csa_c)
  );

  assign fin = assemble(y, lo, steps);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      areg <= '0;
      bsr  <= '0;
      sreg <= '0;
      creg <= '0;
      hi   <= '0;
      lo   <= '0;
    end else if (accept) begin
      areg <= a_in;
      bsr  <= b_in >> DIG;
      sreg <= csa_s;
      creg <= csa_c;
    end else if (step_en) begin
      bsr  <= bsr >> DIG;
      sreg <= csa_s;
      creg <= csa_c;
      lo   <= {y[DIG-1:0], lo[OP_W-1:DIG]};
    end else if (finish) begin
      hi <= fin[PROD_W-1:OP_W];
      lo <= fin[OP_W-1:0];
    end
  end
endmodule

// File: rtl/cim_checker.sv
module cim_checker
  import cim_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            finish,
  input logic [1:0]      wclass,
  input logic [OP_W-1:0] hi
);
  logic             take;
  logic [CNT_W-1:0] exp_q, cnt_q;

  assign take = start && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_q <= '0;
      cnt_q <= '0;
    end else if (take) begin
      exp_q <= class_steps(wclass);
      cnt_q <= '0;
    end else if (busy) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  AST_ACCEPT_BUSY:    assert property (@(posedge clk) disable iff (!rst_n) take |=> busy);                     // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);                    // R6
  AST_NOT_BOTH:       assert property (@(posedge clk) disable iff (!rst_n) !(busy && done));                   // R6
  AST_FINISH_DONE:    assert property (@(posedge clk) disable iff (!rst_n) finish |=> (done && !busy));        // R6
  AST_LATENCY_MATCH:  assert property (@(posedge clk) disable iff (!rst_n) done |-> (cnt_q == exp_q));          // R5
  AST_START_IGNORED:  assert property (@(posedge clk) disable iff (!rst_n) (start && busy && !finish) |=> busy); // R7
  AST_HI_HELD:        assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(hi));              // R8
endmodule

bind csa_iter_mul cim_checker u_cim_checker (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .finish (finish),
  .wclass (wclass),
  .hi     (hi)
);

// File: tb/csa_iter_mul_bench.sv
`timescale 1ns/1ps
module csa_iter_mul_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        is_signed = 1'b0;
  logic [1:0]  wclass = 2'd0;
  logic [63:0] opa = '0;
  logic [63:0] opb = '0;
  logic        busy, done;
  logic [63:0] hi, lo;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  csa_iter_mul u_csa_iter_mul (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
    .wclass(wclass), .opa(opa), .opb(opb),
    .busy(busy), .done(done), .hi(hi), .lo(lo)
  );

  function automatic int width_of(input logic [1:0] wc);
    return (wc == 2'd0) ? 24 : (wc == 2'd1) ? 32 : (wc == 2'd2) ? 54 : 64;
  endfunction

  // R5 latency table
  function automatic int lat_of(input logic [1:0] wc);
    return (wc == 2'd0) ? 3 : (wc == 2'd1) ? 4 : (wc == 2'd2) ? 6 : 7;
  endfunction

  function automatic logic signed [131:0] to_num(input logic [63:0] v, input int w, input logic sg);
    logic signed [131:0] x;
    x = '0;
    for (int i = 0; i < w; i++) x[i] = v[i];
    if (sg && x[w-1]) x = x - (132'sd1 <<< w);
    return x;
  endfunction

  function automatic logic [127:0] ref_mul(input logic [63:0] a, input logic [63:0] b,
                                           input logic sg, input logic [1:0] wc);
    logic signed [131:0] p;
    p = to_num(a, width_of(wc), sg) * to_num(b, width_of(wc), sg);
    return p[127:0];
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // poke: start with other operands one cycle into the run (R7)
  // hold: wait idle cycles and re-read the result (R8)
  // chain: drive start in the current half cycle, which shows done (R9)
  task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic sg,
                        input logic [1:0] wc, input bit poke, input bit hold,
                        input bit chain, input string tag);
    logic [127:0] expv;
    int k;
    expv = ref_mul(a, b, sg, wc);
    if (!chain) @(negedge clk);
    start = 1'b1; opa = a; opb = b; is_signed = sg; wclass = wc;
    @(negedge clk);
    start = 1'b0; k = 0;
    if (poke) begin
      start = 1'b1; opa = ~a; opb = b ^ 64'h5A5A_5A5A_5A5A_5A5A;
      is_signed = ~sg; wclass = wc + 2'd1;
    end
    while (!done && k < 40) begin
      @(negedge clk);
      start = 1'b0;
      k++;
    end
    chk({"R5 ", tag}, 128'(k), 128'(lat_of(wc)));
    chk({"R6 busy at done ", tag}, 128'(busy), 128'd0);
    chk({sg ? "R2/R3 " : "R2/R4 ", tag}, {hi, lo}, expv);
    if (hold) begin
      repeat (3) @(negedge clk);
      chk({"R6 done pulse ", tag}, 128'(done), 128'd0);
      chk({"R8 hold ", tag}, {hi, lo}, expv);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL R5 watchdog: run still active actual=200000 cycles expected=fewer");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    chk("R1 reset outputs", {hi, lo}, 128'd0);
    chk("R1 reset flags", 128'({busy, done}), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {hi, lo} | 128'({busy, done}), 128'd0);

    // directed corners per width and mode
    for (int wc = 0; wc < 4; wc++) begin
      for (int sg = 0; sg < 2; sg++) begin
        int w;
        logic [63:0] mneg, mpos, ones;
        w = width_of(2'(wc));
        ones = '1;
        mneg = 64'd1 << (w - 1);
        mpos = mneg - 64'd1;
        run_op(mneg, mneg, 1'(sg), 2'(wc), 0, 0, 0, "minneg*minneg");
        run_op(ones, ones, 1'(sg), 2'(wc), 0, 0, 0, "ones*ones");
        run_op(mneg, ones, 1'(sg), 2'(wc), 0, 0, 0, "minneg*ones");
        run_op(mpos, mneg, 1'(sg), 2'(wc), 0, 1, 0, "maxpos*minneg");
        run_op(64'd0, ones, 1'(sg), 2'(wc), 0, 0, 0, "zero*ones");
        run_op(64'd1, mpos, 1'(sg), 2'(wc), 0, 0, 0, "one*maxpos");
      end
    end

    // R10: junk above the selected width
    run_op(64'hDEAD_BEEF_00FF_FFFF, 64'hFFFF_0000_0080_0001, 1'b1, 2'd0, 0, 1, 0, "R10 junk 24s");
    run_op(64'hDEAD_BEEF_00FF_FFFF, 64'hFFFF_0000_0080_0001, 1'b0, 2'd0, 0, 1, 0, "R10 junk 24u");
    run_op(64'h1234_5678_8000_0000, 64'hFFFF_FFFF_7FFF_FFFF, 1'b1, 2'd1, 0, 0, 0, "R10 junk 32s");
    run_op(64'hFFC0_0000_0000_0003, 64'h0040_0000_0000_0005, 1'b1, 2'd2, 0, 0, 0, "R10 junk 54s");

    // R7: start during busy is ignored
    for (int wc = 0; wc < 4; wc++)
      run_op(64'h8765_4321_0FED_CBA9, 64'hF0E1_D2C3_B4A5_9687, 1'b1, 2'(wc), 1, 1, 0, "R7 poke");

    // R9: back-to-back chain over all classes
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0003, 1'b1, 2'd3, 0, 0, 0, "R9 head");
    run_op(64'h0000_0000_00AB_CDEF, 64'h0000_0000_0080_0000, 1'b1, 2'd0, 0, 0, 1, "R9 chain a");
    run_op(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 2'd3, 0, 0, 1, "R9 chain b");
    run_op(64'h0020_0000_0000_0001, 64'h003F_FFFF_FFFF_FFFF, 1'b1, 2'd2, 0, 1, 1, "R9 chain c");

    // constrained random
    for (int n = 0; n < 160; n++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (n % 9 == 0) a[63:32] = '1;
      run_op(a, b, 1'($urandom), 2'($urandom), (n % 7) == 3, (n % 5) == 1, 0, "random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule